// File: doc/BRIEF.md
# Single-Step Non-Restoring Divide Unit

This unit performs one iteration of a non-restoring binary division. It takes a partial remainder, a divisor and three status bits: the quotient-sign bit Q, the divisor-sign bit M and the carried quotient bit T. It shifts the remainder left by one place and moves T into the vacated low bit. It then subtracts the divisor when Q equals M and adds it otherwise. From the bit shifted out and the carry or borrow of that operation it forms the new Q and the new T.

A full division is a chain of these steps, issued one after another by an external sequencer. That sequencer feeds `rem_out`, `q_out` and `t_out` back into the next step, with the same divisor and M. M is only an input and the unit never changes it.

The input side is a valid/ready stream. `step_ready` is high in every cycle, so there is no back-pressure, and a step is accepted in any cycle where `step_valid` is high. The result registers on the next rising edge, and `step_done` pulses for exactly that one cycle. The output has no ready signal: the sequencer must take the result in the `step_done` cycle. The outputs then hold until the next accepted step.

Top module: `divstep_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `rem_out`, `q_out`, `t_out` and `step_done` to 0 at the first rising edge where it is sampled high.
- R2: `step_done` is 1 in the cycle after a cycle with `step_valid`=1, and 0 after any cycle with `step_valid`=0.
- R3: When `q_in` equals `m_in`, `rem_out` becomes ((`rem_in` << 1) | `t_in`) minus `divisor_in`, modulo 2^WIDTH. The shift drops the top bit.
- R4: When `q_in` differs from `m_in`, `rem_out` becomes ((`rem_in` << 1) | `t_in`) plus `divisor_in`, modulo 2^WIDTH.
- R5: Let s be bit WIDTH-1 of `rem_in`. Let c be the borrow out of the subtract, or the carry out of the add. The new `q_out` is given by the old Q and M as follows:
  - Q=0, M=0: s XOR c.
  - Q=0, M=1: NOT(s XOR c).
  - Q=1, M=0: s XOR c.
  - Q=1, M=1: NOT(s XOR c).
- R6: The new `t_out` is 1 exactly when the new `q_out` equals `m_in`.
- R7: In a cycle without `step_valid`, `rem_out`, `q_out` and `t_out` keep their values.
- R8: `step_ready` is 1 in every cycle, so a step is never refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_valid | input | 1 | A step request is present this cycle |
| step_ready | output | 1 | Always 1; a step is accepted whenever it is valid |
| rem_in | input | WIDTH | Partial remainder before the step |
| divisor_in | input | WIDTH | Divisor |
| q_in | input | 1 | Q bit before the step |
| m_in | input | 1 | Divisor sign bit M (read only) |
| t_in | input | 1 | T bit, shifted into bit 0 of the remainder |
| rem_out | output | WIDTH | Partial remainder after the last accepted step |
| q_out | output | 1 | Q after the last accepted step |
| t_out | output | 1 | T after the last accepted step |
| step_done | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The bench builds the unit with its default WIDTH of 32. At that width, carries and borrows out of the top bit come from plain 64-bit integer arithmetic in the model. Directed steps cover all four Q/M combinations at the extremes: a zero divisor, an all-ones remainder, and a shifted value equal to the divisor. Random steps with gaps in `step_valid` then exercise the hold behaviour and the single-cycle done pulse.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } divstep_op_e;
endpackage

// File: rtl/divstep_core.sv
module divstep_core
  import divstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] rem,
  input  logic [WIDTH-1:0] dvsr,
  input  logic             q_old,
  input  logic             m_sign,
  input  logic             t_bit,
  output logic [WIDTH-1:0] rem_nxt,
  output logic             q_nxt,
  output logic             t_nxt,
  output divstep_op_e      op
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] shifted;
  logic             out_bit;
  logic [WIDTH:0]   wide;
  logic             cy;

  assign shifted = {rem[TOP-1:0], t_bit};
  assign out_bit = rem[TOP];
  assign op      = (q_old == m_sign) ? OP_SUB : OP_ADD;

  always_comb begin
    if (op == OP_SUB) wide = {1'b0, shifted} - {1'b0, dvsr};
    else              wide = {1'b0, shifted} + {1'b0, dvsr};
  end

  assign cy      = wide[WIDTH];
  assign rem_nxt = wide[TOP:0];

  // New Q from the old Q/M pair and the carry or borrow
  always_comb begin
    unique case ({q_old, m_sign})
      2'b00:   q_nxt = out_bit ^ cy;
      2'b01:   q_nxt = ~(out_bit ^ cy);
      2'b10:   q_nxt = out_bit ^ cy;
      default: q_nxt = ~(out_bit ^ cy);
    endcase
  end

  assign t_nxt = (q_nxt == m_sign);

  always_comb begin
    if (op == OP_SUB) begin
      assert (rem_nxt + dvsr == shifted) else $error("AST_SUB_INVERTS"); // R3
    end else begin
      assert (rem_nxt - dvsr == shifted) else $error("AST_ADD_INVERTS"); // R4
    end
  end
endmodule

// File: rtl/divstep_oreg.sv
module divstep_oreg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d_rem,
  input  logic             d_q,
  input  logic             d_t,
  output logic [WIDTH-1:0] o_rem,
  output logic             o_q,
  output logic             o_t,
  output logic             o_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      o_rem  <= '0;
      o_q    <= 1'b0;
      o_t    <= 1'b0;
      o_done <= 1'b0;
    end else begin
      o_done <= load;
      if (load) begin
        o_rem <= d_rem;
        o_q   <= d_q;
        o_t   <= d_t;
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(o_rem) && $stable(o_q) && $stable(o_t))) else $error("AST_HOLD_IDLE"); // R7
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_valid,
  output logic             step_ready,
  input  logic [WIDTH-1:0] rem_in,
  input  logic [WIDTH-1:0] divisor_in,
  input  logic             q_in,
  input  logic             m_in,
  input  logic             t_in,
  output logic [WIDTH-1:0] rem_out,
  output logic             q_out,
  output logic             t_out,
  output logic             step_done
);
  logic [WIDTH-1:0] rem_c;
  logic             q_c;
  logic             t_c;
  divstep_op_e      op_c;

  assign step_ready = 1'b1;

  divstep_core #(.WIDTH(WIDTH)) u_core (
    .rem     (rem_in),
    .dvsr    (divisor_in),
    .q_old   (q_in),
    .m_sign  (m_in),
    .t_bit   (t_in),
    .rem_nxt (rem_c),
    .q_nxt   (q_c),
    .t_nxt   (t_c),
    .op      (op_c)
  );

  divstep_oreg #(.WIDTH(WIDTH)) u_oreg (
    .clk    (clk),
    .rst    (rst),
    .load   (step_valid & step_ready),
    .d_rem  (rem_c),
    .d_q    (q_c),
    .d_t    (t_c),
    .o_rem  (rem_out),
    .o_q    (q_out),
    .o_t    (t_out),
    .o_done (step_done)
  );

  AST_DONE_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    step_valid |=> step_done) else $error("AST_DONE_AFTER_STEP"); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !step_valid |=> !step_done) else $error("AST_NO_SPURIOUS_DONE"); // R2
  AST_T_TRACKS_M: assert property (@(posedge clk) disable iff (rst)
    step_valid |=> (t_out == (q_out == $past(m_in)))) else $error("AST_T_TRACKS_M"); // R6
  AST_OP_CHOICE: assert property (@(posedge clk) disable iff (rst)
    step_valid |-> ((op_c == OP_SUB) == (q_in == m_in))) else $error("AST_OP_CHOICE"); // R3
endmodule

// File: tb/tb_divstep_unit.sv
module tb_divstep_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         step_valid;
  logic         step_ready;
  logic [W-1:0] rem_in, divisor_in;
  logic         q_in, m_in, t_in;
  logic [W-1:0] rem_out;
  logic         q_out, t_out, step_done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference state
  longint exp_rem;
  bit     exp_q, exp_t, exp_done;
  string  rem_tag;

  always #5 clk = ~clk;

  divstep_unit #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .step_valid(step_valid), .step_ready(step_ready),
    .rem_in(rem_in), .divisor_in(divisor_in), .q_in(q_in), .m_in(m_in), .t_in(t_in),
    .rem_out(rem_out), .q_out(q_out), .t_out(t_out), .step_done(step_done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_outputs();
    chk(rem_tag, longint'(rem_out), exp_rem);
    chk("R5 q_out", longint'(q_out), longint'(exp_q));
    chk("R6 t_out", longint'(t_out), longint'(exp_t));
    chk("R2 step_done", longint'(step_done), longint'(exp_done));
    chk("R8 step_ready", longint'(step_ready), 1);
  endtask

  // One cycle: check what the last edge produced, then drive and predict
  task automatic cycle(input bit r, input bit v, input longint rm, input longint dv,
                       input bit q, input bit m, input bit t);
    longint mask, sh, res;
    bit s, c;
    @(negedge clk);
    compare_outputs();
    rst = r; step_valid = v;
    rem_in = rm[W-1:0]; divisor_in = dv[W-1:0];
    q_in = q; m_in = m; t_in = t;
    mask = (longint'(1) << W) - 1;
    if (r) begin
      exp_rem = 0; exp_q = 0; exp_t = 0; exp_done = 0; rem_tag = "R1 rem_out";
    end else if (v) begin
      s  = rm[W-1];
      sh = ((rm << 1) & mask) | longint'(t);
      if (q == m) begin
        c = (sh < (dv & mask));
        res = (sh - (dv & mask)) & mask;
        rem_tag = "R3 rem_out";
      end else begin
        res = sh + (dv & mask);
        c = (res > mask);
        res = res & mask;
        rem_tag = "R4 rem_out";
      end
      exp_rem = res;
      if (!q && !m)     exp_q = s ^ c;
      else if (!q && m) exp_q = !(s ^ c);
      else if (q && !m) exp_q = s ^ c;
      else              exp_q = !(s ^ c);
      exp_t = (exp_q == m);
      exp_done = 1;
    end else begin
      exp_done = 0; rem_tag = "R7 rem_out hold";
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; step_valid = 0; rem_in = '0; divisor_in = '0;
    q_in = 0; m_in = 0; t_in = 0;
    exp_rem = 0; exp_q = 0; exp_t = 0; exp_done = 0; rem_tag = "R1 rem_out";
    repeat (2) @(negedge clk);
    // R1: reset state observed from here on
    cycle(1, 1, 64'h1234, 64'h1, 1, 1, 1);
    // directed: all four Q/M pairs (R3 R4 R5 R6)
    cycle(0, 1, 64'h4000_0000, 64'h3000_0000, 0, 0, 1);
    cycle(0, 1, 64'h8000_0001, 64'h0000_0005, 0, 1, 0);
    cycle(0, 1, 64'hFFFF_FFFF, 64'h0000_0002, 1, 0, 1);
    cycle(0, 1, 64'h7FFF_FFFF, 64'hFFFF_FFFF, 1, 1, 0);
    // boundaries: zero divisor, shifted value equal to divisor, all ones
    cycle(0, 1, 64'hFFFF_FFFF, 64'h0, 0, 0, 1);
    cycle(0, 1, 64'h0000_0010, 64'h0000_0021, 1, 1, 1);
    cycle(0, 1, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 0, 1, 1);
    cycle(0, 1, 64'h0, 64'h0, 1, 0, 0);
    // R7: idle cycles with changing inputs
    cycle(0, 0, 64'hDEAD_BEEF, 64'h1, 0, 0, 0);
    cycle(0, 0, 64'h1, 64'hFFFF_0000, 1, 0, 1);
    // mid-stream reset (R1)
    cycle(0, 1, 64'hAAAA_5555, 64'h1357_9BDF, 0, 0, 0);
    cycle(1, 0, 64'h0, 64'h0, 0, 0, 0);
    // random traffic, including feedback chains
    for (int i = 0; i < 600; i++) begin
      bit v;
      v = ($urandom_range(0, 9) < 7);
      if (i % 3 == 0 && exp_done)
        cycle(0, v, exp_rem, longint'($urandom), exp_q, m_in, exp_t);
      else
        cycle(0, v, longint'($urandom), longint'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom));
    end
    cycle(0, 0, 64'h0, 64'h0, 0, 0, 0);
    @(negedge clk);
    compare_outputs();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule